// File: doc/BRIEF.md
# Issue-Queue Parallelism Estimator

This block watches the stream of renamed instructions during one measurement interval and estimates how much dataflow parallelism an issue queue of each of four candidate sizes (16, 32, 48 and 64 entries by default) could expose. It keeps a completion timestamp for every architectural register. A free-running cycle counter drives these timestamps and restarts at each interval. Each instruction's completion time is its latest-ready source plus its execution latency.

The largest completion time seen over the first N instructions of the interval is recorded at each window boundary. That value is the critical-path length for a queue that could look N instructions ahead. After the last window closes, the block weighs each size by a relative clock frequency and reports the size with the best weighted ratio of instructions to critical path. It compares cross-products, so no division is needed. A controller that resizes the queue samples the result at the end of the interval and starts the next interval with a single pulse.

Top module: `iqe_ilp_estimator`

## Requirements
- R1: After reset, result_vld is 0, best_idx is 0 and every win_max field is 0.
- R2: The cycle counter reads 0 in the cycle that carries intv_start and rises by one every following clock cycle, whether or not an instruction is presented.
- R3: An accepted instruction completes at the latest ready time among its valid sources plus its latency. With dst_vld set, that completion time becomes the timestamp of register dst_tag.
- R4: A source whose register timestamp is not later than the current counter value, or a source whose valid bit is 0, is ready at the current counter value.
- R5: An exec_lat of 0 is treated as a latency of 1.
- R6: An instruction with dst_vld at 0 still counts toward the windows and the maxima but leaves every register timestamp unchanged.
- R7: win_max field i (bits [16*i +: 16]) holds the largest completion time among the first 16*(i+1) instructions of the interval. It is written in the cycle that accepts the instruction closing that window.
- R8: result_vld goes high at the second rising edge after the cycle that presents the 64th instruction. Instructions after the 64th are ignored until the next interval. While result_vld is high without intv_start, best_idx and win_max hold.
- R9: best_idx picks the size i that maximises N_i*f_i/win_max_i, with N_i = 16*(i+1) and default weights f = 16, 14, 12, 11 for codes 0..3. best_entries equals 16*(best_idx+1).
- R10: When two sizes give equal weighted ratios, the smaller size (lower code) is chosen.
- R11: intv_start clears the counter, all register timestamps, the instruction count, win_max and result_vld. An instruction presented in the same cycle is the first of the new interval and sees the cleared state.
- R12: best_idx and best_entries keep the previous interval's choice until the new interval produces its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| intv_start | input | 1 | Begins a new measurement interval in this cycle |
| ren_vld | input | 1 | A renamed instruction is presented |
| src0_vld | input | 1 | First source operand is a register |
| src0_tag | input | 5 | First source register number |
| src1_vld | input | 1 | Second source operand is a register |
| src1_tag | input | 5 | Second source register number |
| dst_vld | input | 1 | Instruction writes a destination register |
| dst_tag | input | 5 | Destination register number |
| exec_lat | input | 4 | Execution latency in cycles |
| result_vld | output | 1 | Choice for the current interval is available |
| best_idx | output | 2 | Chosen size code (0..3) |
| best_entries | output | 7 | Chosen queue size in entries |
| win_max | output | 64 | Recorded maximum completion time per window |

## Verification
The sharpest coincidence is an interval restart in the same cycle as a renamed instruction. If that happens, the table clear and the instruction's own table read and write must both act in one cycle. The bench first builds large timestamps in a register over a partial interval. It then raises intv_start together with an instruction that reads and writes that register. The scoreboard's expected maxima show whether the instruction saw the cleared counter and table. A second coincidence is the result being registered while surplus instructions keep arriving. This is judged by checking that win_max and best_idx are unchanged after a burst of long-latency extras.

// File: rtl/iqe_pkg.sv
package iqe_pkg;
   // number of candidate queue sizes evaluated per interval
   localparam int unsigned IQE_NUM_SIZES = 4;
   // width of the cross-product comparison
   localparam int unsigned IQE_PROD_W = 64;
   typedef logic [IQE_PROD_W-1:0] iqe_prod_t;
endpackage

// File: rtl/iqe_ts_table.sv
// Per-register completion timestamps, two read ports, one write port,
// bulk clear at interval start (reads return zero while clearing).
module iqe_ts_table #(
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned TS_W     = 16,
   localparam int unsigned TAG_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [TAG_W-1:0]  rd0_tag,
   input  logic [TAG_W-1:0]  rd1_tag,
   output logic [TS_W-1:0]   rd0_ts,
   output logic [TS_W-1:0]   rd1_ts,
   input  logic              wr_en,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [TS_W-1:0]   wr_ts
);

   logic [NUM_REGS*TS_W-1:0] ent_flat;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
      logic          hit;
      logic [TS_W-1:0] ent_q;
      assign hit = wr_en && (wr_tag == TAG_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q <= '0;
         end else if (hit) begin
            ent_q <= wr_ts;
         end else if (clr) begin
            ent_q <= '0;
         end
      end
      assign ent_flat[g*TS_W +: TS_W] = ent_q;
   end

   assign rd0_ts = clr ? '0 : ent_flat[rd0_tag*TS_W +: TS_W];
   assign rd1_ts = clr ? '0 : ent_flat[rd1_tag*TS_W +: TS_W];

endmodule

// File: rtl/iqe_window_max.sv
// Counts accepted instructions and records the running maximum completion
// time at every window boundary (STEP, 2*STEP, ...).
module iqe_window_max #(
   parameter int unsigned TS_W      = 16,
   parameter int unsigned STEP      = 16,
   parameter int unsigned NUM_SIZES = 4,
   localparam int unsigned TOTAL    = STEP * NUM_SIZES,
   localparam int unsigned CNT_W    = $clog2(TOTAL + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic                      ins_vld,
   input  logic [TS_W-1:0]           ins_done_ts,
   output logic                      accept,
   output logic [CNT_W-1:0]          cnt,
   output logic [NUM_SIZES*TS_W-1:0] win_max
);

   logic [CNT_W-1:0] cnt_q, base_cnt, new_cnt;
   logic [TS_W-1:0]  run_q, base_run, new_run;

   assign base_cnt = clr ? '0 : cnt_q;
   assign base_run = clr ? '0 : run_q;
   assign accept   = ins_vld && (base_cnt != CNT_W'(TOTAL));
   assign new_run  = (accept && (ins_done_ts > base_run)) ? ins_done_ts : base_run;
   assign new_cnt  = base_cnt + CNT_W'(accept);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= '0;
      end else begin
         cnt_q <= new_cnt;
         run_q <= new_run;
      end
   end

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_win
      logic          close;
      logic [TS_W-1:0] cap_q;
      assign close = accept && (new_cnt == CNT_W'((g + 1) * STEP));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cap_q <= '0;
         end else if (close) begin
            cap_q <= new_run;
         end else if (clr) begin
            cap_q <= '0;
         end
      end
      assign win_max[g*TS_W +: TS_W] = cap_q;
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/iqe_size_pick.sv
// Chooses the size with the largest weighted ratio N_i*f_i/MAX_i using
// cross-products; a later size replaces the current pick only if strictly
// better, so ties keep the smaller size.
module iqe_size_pick
   import iqe_pkg::*;
#(
   parameter int unsigned TS_W      = 16,
   parameter int unsigned STEP      = 16,
   parameter int unsigned NUM_SIZES = 4,
   parameter int unsigned FREQ_W    = 8,
   parameter logic [NUM_SIZES*FREQ_W-1:0] FREQ = '1,
   localparam int unsigned IDX_W    = $clog2(NUM_SIZES)
) (
   input  logic [NUM_SIZES*TS_W-1:0] win_max,
   output logic [IDX_W-1:0]          best
);

   function automatic iqe_prod_t weight(input int unsigned i);
      return iqe_prod_t'((i + 1) * STEP) * iqe_prod_t'(FREQ[i*FREQ_W +: FREQ_W]);
   endfunction

   iqe_prod_t cur_w, cur_m, cand_m;

   always_comb begin
      best  = '0;
      cur_w = weight(0);
      cur_m = iqe_prod_t'(win_max[0 +: TS_W]);
      for (int unsigned i = 1; i < NUM_SIZES; i++) begin
         cand_m = iqe_prod_t'(win_max[i*TS_W +: TS_W]);
         if (weight(i) * cur_m > cur_w * cand_m) begin
            best  = IDX_W'(i);
            cur_w = weight(i);
            cur_m = cand_m;
         end
      end
   end

endmodule

// File: rtl/iqe_ilp_estimator.sv
// Top: cycle counter, dataflow timestamp computation, result register.
module iqe_ilp_estimator
   import iqe_pkg::*;
#(
   parameter int unsigned NUM_REGS  = 32,
   parameter int unsigned TS_W      = 16,
   parameter int unsigned LAT_W     = 4,
   parameter int unsigned STEP      = 16,
   parameter int unsigned NUM_SIZES = IQE_NUM_SIZES,
   parameter int unsigned FREQ_W    = 8,
   parameter logic [NUM_SIZES*FREQ_W-1:0] FREQ = {8'd11, 8'd12, 8'd14, 8'd16},
   localparam int unsigned TAG_W    = $clog2(NUM_REGS),
   localparam int unsigned IDX_W    = $clog2(NUM_SIZES),
   localparam int unsigned TOTAL    = STEP * NUM_SIZES,
   localparam int unsigned CNT_W    = $clog2(TOTAL + 1),
   localparam int unsigned ENT_W    = $clog2(TOTAL + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      intv_start,
   input  logic                      ren_vld,
   input  logic                      src0_vld,
   input  logic [TAG_W-1:0]          src0_tag,
   input  logic                      src1_vld,
   input  logic [TAG_W-1:0]          src1_tag,
   input  logic                      dst_vld,
   input  logic [TAG_W-1:0]          dst_tag,
   input  logic [LAT_W-1:0]          exec_lat,
   output logic                      result_vld,
   output logic [IDX_W-1:0]          best_idx,
   output logic [ENT_W-1:0]          best_entries,
   output logic [NUM_SIZES*TS_W-1:0] win_max
);

   // elaboration-time parameter checks
   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_chk_regs
      $error("NUM_REGS must be a power of two of at least 2");
   end
   if (NUM_SIZES != IQE_NUM_SIZES) begin : g_chk_sizes
      $error("NUM_SIZES must match the package size count");
   end
   if (TS_W <= LAT_W || TS_W < 8) begin : g_chk_ts
      $error("TS_W must exceed LAT_W and be at least 8");
   end
   if (STEP < 1 || FREQ_W < 1) begin : g_chk_step
      $error("STEP and FREQ_W must be positive");
   end
   if (TS_W + CNT_W + FREQ_W > IQE_PROD_W) begin : g_chk_prod
      $error("cross-product width too small for these parameters");
   end

   // cycle counter, saturating
   logic [TS_W-1:0] cnt_q, cnt_now;
   assign cnt_now = intv_start ? '0 : cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= (cnt_now == {TS_W{1'b1}}) ? cnt_now : cnt_now + 1'b1;
      end
   end

   // operand readiness and completion time
   logic [TS_W-1:0]  rd0_ts, rd1_ts, rdy0, rdy1, latest, done_ts;
   logic [LAT_W-1:0] lat_eff;
   logic [TS_W:0]    done_sum;
   logic             accept;

   assign rdy0     = (src0_vld && (rd0_ts > cnt_now)) ? rd0_ts : cnt_now;
   assign rdy1     = (src1_vld && (rd1_ts > cnt_now)) ? rd1_ts : cnt_now;
   assign latest   = (rdy1 > rdy0) ? rdy1 : rdy0;
   assign lat_eff  = (exec_lat == '0) ? LAT_W'(1) : exec_lat;
   assign done_sum = {1'b0, latest} + (TS_W + 1)'(lat_eff);
   assign done_ts  = done_sum[TS_W] ? {TS_W{1'b1}} : done_sum[TS_W-1:0];

   iqe_ts_table #(
      .NUM_REGS (NUM_REGS),
      .TS_W     (TS_W)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (intv_start),
      .rd0_tag (src0_tag),
      .rd1_tag (src1_tag),
      .rd0_ts  (rd0_ts),
      .rd1_ts  (rd1_ts),
      .wr_en   (accept && dst_vld),
      .wr_tag  (dst_tag),
      .wr_ts   (done_ts)
   );

   logic [CNT_W-1:0] win_cnt;
   logic             win_full;

   iqe_window_max #(
      .TS_W      (TS_W),
      .STEP      (STEP),
      .NUM_SIZES (NUM_SIZES)
   ) u_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (intv_start),
      .ins_vld     (ren_vld),
      .ins_done_ts (done_ts),
      .accept      (accept),
      .cnt         (win_cnt),
      .win_max     (win_max)
   );

   assign win_full = (win_cnt == CNT_W'(TOTAL));

   logic [IDX_W-1:0] pick;

   iqe_size_pick #(
      .TS_W      (TS_W),
      .STEP      (STEP),
      .NUM_SIZES (NUM_SIZES),
      .FREQ_W    (FREQ_W),
      .FREQ      (FREQ)
   ) u_pick (
      .win_max (win_max),
      .best    (pick)
   );

   // result register
   logic             res_q;
   logic [IDX_W-1:0] best_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q  <= 1'b0;
         best_q <= '0;
      end else if (intv_start) begin
         res_q  <= 1'b0;
      end else if (win_full && !res_q) begin
         res_q  <= 1'b1;
         best_q <= pick;
      end
   end

   assign result_vld   = res_q;
   assign best_idx     = best_q;
   assign best_entries = ENT_W'((32'(best_q) + 32'd1) * STEP);

endmodule

// File: rtl/iqe_ilp_estimator_chk.sv
// Temporal properties of the estimator, attached by bind.
module iqe_ilp_estimator_chk #(
   parameter int unsigned TS_W      = 16,
   parameter int unsigned STEP      = 16,
   parameter int unsigned NUM_SIZES = 4,
   localparam int unsigned IDX_W    = $clog2(NUM_SIZES),
   localparam int unsigned TOTAL    = STEP * NUM_SIZES,
   localparam int unsigned CNT_W    = $clog2(TOTAL + 1)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      intv_start,
   input logic                      ren_vld,
   input logic                      result_vld,
   input logic [IDX_W-1:0]          best_idx,
   input logic [NUM_SIZES*TS_W-1:0] win_max,
   input logic [TS_W-1:0]           cnt_now,
   input logic [TS_W-1:0]           done_ts,
   input logic [CNT_W-1:0]          win_cnt
);

   AST_START_DROPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      intv_start |=> !result_vld); // R11

   AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (result_vld && !intv_start) |=> (result_vld && $stable(best_idx) && $stable(win_max))); // R8

   AST_RESULT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(result_vld) |-> (win_cnt == CNT_W'(TOTAL))); // R8

   AST_DONE_AFTER_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      ren_vld |-> ((done_ts > cnt_now) || (done_ts == {TS_W{1'b1}}))); // R5

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_floor
      AST_WINDOW_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
         result_vld |-> (win_max[g*TS_W +: TS_W] >= TS_W'((g + 1) * STEP))); // R7
   end

   for (genvar g = 0; g + 1 < NUM_SIZES; g++) begin : g_nest
      AST_WINDOWS_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
         result_vld |-> (win_max[(g+1)*TS_W +: TS_W] >= win_max[g*TS_W +: TS_W])); // R7
   end

endmodule

bind iqe_ilp_estimator iqe_ilp_estimator_chk #(
   .TS_W      (TS_W),
   .STEP      (STEP),
   .NUM_SIZES (NUM_SIZES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .intv_start (intv_start),
   .ren_vld    (ren_vld),
   .result_vld (result_vld),
   .best_idx   (best_idx),
   .win_max    (win_max),
   .cnt_now    (cnt_now),
   .done_ts    (done_ts),
   .win_cnt    (win_cnt)
);

// File: tb/iqe_ilp_estimator_tb.sv
module iqe_ilp_estimator_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        intv_start = 1'b0, ren_vld = 1'b0;
   logic        src0_vld = 1'b0, src1_vld = 1'b0, dst_vld = 1'b0;
   logic [4:0]  src0_tag = '0, src1_tag = '0, dst_tag = '0;
   logic [3:0]  exec_lat = '0;
   logic        result_vld;
   logic [1:0]  best_idx;
   logic [6:0]  best_entries;
   logic [63:0] win_max;

   always #2 clk = ~clk;   // 250 MHz

   iqe_ilp_estimator u_dut (
      .clk(clk), .rst_n(rst_n), .intv_start(intv_start), .ren_vld(ren_vld),
      .src0_vld(src0_vld), .src0_tag(src0_tag), .src1_vld(src1_vld), .src1_tag(src1_tag),
      .dst_vld(dst_vld), .dst_tag(dst_tag), .exec_lat(exec_lat),
      .result_vld(result_vld), .best_idx(best_idx), .best_entries(best_entries),
      .win_max(win_max)
   );

   typedef struct packed {
      logic [3:0][15:0] mx;
      logic [1:0]       best;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   exp_t  last_exp;
   string cur_tag = "R3";

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // reference model state (from the requirements)
   int m_cnt, m_n, m_run;
   int m_ts[32];
   int m_max[4];
   int freq_w[4] = '{16, 14, 12, 11};

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int pick_best(input int mx[4]);
      int b = 0;
      for (int g = 1; g < 4; g++)
         if (longint'((g + 1) * 16 * freq_w[g]) * mx[b] > longint'((b + 1) * 16 * freq_w[b]) * mx[g])
            b = g;
      return b;
   endfunction

   task automatic issue(input bit st, input bit v, input bit s0v, input int s0,
                        input bit s1v, input int s1, input bit dv, input int d, input int lat);
      int r0, r1, dn;
      exp_t e;
      @(negedge clk);
      intv_start = st; ren_vld = v;
      src0_vld = s0v; src0_tag = 5'(s0); src1_vld = s1v; src1_tag = 5'(s1);
      dst_vld = dv; dst_tag = 5'(d); exec_lat = 4'(lat);
      if (st) begin
         m_cnt = 0; m_n = 0; m_run = 0;
         for (int k = 0; k < 32; k++) m_ts[k] = 0;
      end else begin
         m_cnt++;
      end
      if (v && m_n < 64) begin
         r0 = (s0v && m_ts[s0] > m_cnt) ? m_ts[s0] : m_cnt;
         r1 = (s1v && m_ts[s1] > m_cnt) ? m_ts[s1] : m_cnt;
         dn = ((r0 > r1) ? r0 : r1) + ((lat == 0) ? 1 : lat);
         if (dv) m_ts[d] = dn;
         if (dn > m_run) m_run = dn;
         m_n++;
         if (m_n % 16 == 0) m_max[m_n / 16 - 1] = m_run;
         if (m_n == 64) begin
            for (int g = 0; g < 4; g++) e.mx[g] = 16'(m_max[g]);
            e.best = 2'(pick_best(m_max));
            exp_q.push_back(e);
            tag_q.push_back(cur_tag);
            last_exp = e;
         end
      end
   endtask

   task automatic idle();
      issue(0, 0, 0, 0, 0, 0, 0, 0, 1);
   endtask

   // monitor: pops the expected item when a result appears
   initial begin
      bit prev = 0;
      exp_t e;
      string t;
      forever begin
         @(negedge clk);
         if (rst_n && result_vld && !prev) begin
            if (exp_q.size() == 0) begin
               check("R8 unexpected result", 1, 0);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               for (int g = 0; g < 4; g++)
                  check({t, " R7 win_max field"}, win_max[g*16 +: 16], e.mx[g]);
               check({t, " R9 best_idx"}, best_idx, e.best);
               check({t, " R9 best_entries"}, best_entries, 16 * (e.best + 1));
            end
         end
         prev = result_vld;
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 result_vld", result_vld, 0);
      check("R1 best_idx", best_idx, 0);
      check("R1 win_max", win_max, 0);

      // independent single-cycle ops, back to back
      cur_tag = "R2";
      for (int i = 0; i < 64; i++) issue(i == 0, 1, 0, 0, 0, 0, 1, i % 32, 1);
      idle(); idle();

      // independent long ops: size 32 wins; result timing and surplus ops
      cur_tag = "R9";
      for (int i = 0; i < 64; i++) issue(i == 0, 1, 0, 0, 0, 0, 1, i % 32, 15);
      idle();
      check("R8 result not yet", result_vld, 0);
      idle();
      check("R8 result valid", result_vld, 1);
      check("R9 hand value idx", best_idx, 1);
      check("R9 hand value entries", best_entries, 32);
      for (int i = 0; i < 10; i++) issue(0, 1, 1, 1, 0, 0, 1, 1, 15);
      idle();
      check("R8 surplus ignored win_max", win_max, last_exp.mx);
      check("R8 surplus ignored best", best_idx, last_exp.best);

      // bare interval start
      issue(1, 0, 0, 0, 0, 0, 0, 0, 1);
      idle();
      check("R11 result cleared", result_vld, 0);
      check("R11 win_max cleared", win_max, 0);
      check("R12 previous choice kept", best_idx, last_exp.best);
      check("R12 previous entries kept", best_entries, 16 * (last_exp.best + 1));

      // partial interval builds a long chain in r1, then restart in the same
      // cycle as an instruction that reads r1
      for (int i = 0; i < 20; i++) issue(0, 1, 1, 1, 0, 0, 1, 1, 15);
      cur_tag = "R11";
      issue(1, 1, 1, 1, 1, 1, 1, 1, 1);
      for (int i = 1; i < 64; i++) issue(0, 1, 1, 1, 0, 0, 1, 1, (i % 3) + 1);
      idle(); idle();
      check("R12 new choice after restart", best_idx, last_exp.best);

      // tie between sizes 16 and 32 (8 == 8)
      cur_tag = "R10";
      for (int i = 0; i < 64; i++) begin
         case (i)
            0:                   issue(1, 1, 0, 0, 0, 0, 1, 1, 15);
            1, 16, 32, 33, 48:   issue(0, 1, 1, 1, 0, 0, 1, 1, 15);
            2:                   issue(0, 1, 1, 1, 0, 0, 1, 1, 2);
            17:                  issue(0, 1, 1, 1, 0, 0, 1, 1, 9);
            default:             issue(0, 1, 0, 0, 0, 0, 1, 2, 1);
         endcase
      end
      idle(); idle();
      check("R10 tie keeps smaller", best_idx, 0);

      // no-destination long ops interleaved with zero-latency readers
      cur_tag = "R6 R5";
      for (int i = 0; i < 64; i++) begin
         if (i % 2 == 0) issue(i == 0, 1, 0, 0, 0, 0, 0, 3, 15);
         else            issue(0, 1, 1, 3, 0, 0, 1, 4, 0);
      end
      idle(); idle();

      // bubbles: counter advances on empty cycles
      cur_tag = "R2";
      issue(1, 1, 0, 0, 0, 0, 1, 0, 1);
      for (int i = 1; i < 64; i++) begin
         if (i % 3 == 0) idle();
         issue(0, 1, 0, 0, 1, 5, 1, 6, 1);
      end
      idle(); idle();

      // random dependency mixes
      cur_tag = "R4";
      for (int r = 0; r < 6; r++) begin
         issue(1, 1, 0, 0, 0, 0, 1, 0, 1);
         for (int i = 0; i < 75; i++) begin
            if ($urandom_range(0, 3) == 0) idle();
            issue(0, 1, 1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                  1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                  1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                  int'($urandom_range(0, 15)));
         end
         idle(); idle();
      end
      check("R8 scoreboard drained", exp_q.size(), 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule